// File: doc/BRIEF.md
# Address-Range Access Watchpoint Unit

This block sits beside a memory arbiter and watches every access the arbiter passes on. It holds a small bank of watchpoints. Each one has an inclusive address window, a mask of the clients it cares about and a mask of the operation types (read, write) it cares about. When a snooped access falls in the window, comes from a selected client and has a selected operation, that watchpoint's pending bit is set. The details of the offending access are also latched for software to read. The access itself is never stalled or blocked.

Software programs the watchpoints and reads the captured details through a simple word-indexed register port. The single interrupt output is the OR of the pending bits that are enabled in an interrupt enable register. A masked status word also reports the lowest-numbered enabled pending watchpoint, so a handler can serve them in index order. Pending bits are cleared through a global acknowledge register. The capture of each watchpoint is released by that watchpoint's own acknowledge register.

Top module: `addr_watch_unit`

## Requirements
- R1: After reset `irq` is 0, and every configuration, capture, enable and status register reads 0.
- R2: Watchpoint w owns register indices w*8+0 (window low address), w*8+1 (window high address), w*8+2 (operation mask in bits [1:0]) and w*8+3 (client mask, bit c for client id c). Each of these reads back the value last written.
- R3: An access hits only when it is valid and low <= address <= high, with both bounds included.
- R4: An access hits only when the client-mask bit indexed by its client id is 1.
- R5: An access hits only when its operation is enabled in the operation mask: bit 0 enables reads (`snp_write`=0) and bit 1 enables writes (`snp_write`=1).
- R6: A hit sets the watchpoint's pending bit, visible one cycle later as bit w of the raw status at index NUM_WP*8+1. This happens whatever the interrupt enable says.
- R7: The first hit while the capture is empty latches the address (index w*8+5), the operation and the size (index w*8+6: bit 0 = write, bits [15:8] = size, bit 31 = capture valid) and the client id (index w*8+7). Later hits leave these fields unchanged.
- R8: The captured client set (index w*8+4) is the OR of the one-hot client bits of every hit since the capture was last empty.
- R9: Writing any value to index w*8+7 empties watchpoint w's capture (all capture fields read 0). A hit in the same cycle starts a fresh capture.
- R10: Writing 1 to bit w of the global acknowledge at index NUM_WP*8+3 clears pending bit w. A hit on that watchpoint in the same cycle keeps it set.
- R11: The interrupt enable at index NUM_WP*8+0 has bit w for watchpoint w. The masked status at NUM_WP*8+2 carries pending AND enable in bits [NUM_WP-1:0], and `irq` is the OR of those bits.
- R12: The masked status also carries, in bits [23:16], the index of the lowest-numbered enabled pending watchpoint, with bit 31 set when there is any such watchpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| snp_valid | input | 1 | A snooped access is present this cycle |
| snp_addr | input | 32 | Snooped access address |
| snp_client | input | 4 | Id of the client making the access |
| snp_write | input | 1 | 1 for a write, 0 for a read |
| snp_size | input | 8 | Size of the access |
| irq | output | 1 | Interrupt: any enabled pending watchpoint |

## Verification
The bench runs accesses at exactly the low and high bounds and one word outside each, to catch off-by-one window compares. It also runs accesses from an unselected client and with an unselected operation, which a design with a loose mask decode would wrongly flag. A second hit from another client checks that address, size and first client stay frozen while the client set grows. A design that overwrote the capture, or failed to accumulate, would miscompare there. Acknowledge and hit are driven in the same cycle to expose a clear that wins over a set. Two enabled pending watchpoints check that the lowest index is reported, and that it moves to the next one once the lower is cleared.

// File: rtl/aw_pkg.sv
package aw_pkg;

    localparam int AW        = 32;
    localparam int DW        = 32;
    localparam int NCLI      = 16;
    localparam int CIDW      = $clog2(NCLI);
    localparam int SZW       = 8;
    localparam int SLOT_SPAN = 8;

    // per-watchpoint register offsets
    localparam logic [2:0] OFF_LO    = 3'd0;
    localparam logic [2:0] OFF_HI    = 3'd1;
    localparam logic [2:0] OFF_OPM   = 3'd2;
    localparam logic [2:0] OFF_CMASK = 3'd3;
    localparam logic [2:0] OFF_CCLI  = 3'd4;
    localparam logic [2:0] OFF_CADDR = 3'd5;
    localparam logic [2:0] OFF_CINFO = 3'd6;
    localparam logic [2:0] OFF_CFRST = 3'd7;

    // global register offsets
    localparam logic [2:0] GOFF_EN   = 3'd0;
    localparam logic [2:0] GOFF_RAW  = 3'd1;
    localparam logic [2:0] GOFF_MSK  = 3'd2;
    localparam logic [2:0] GOFF_ACK  = 3'd3;

    typedef struct packed {
        logic [AW-1:0]   lo;
        logic [AW-1:0]   hi;
        logic [1:0]      opm;
        logic [NCLI-1:0] cmask;
    } aw_cfg_t;

    typedef struct packed {
        logic            valid;
        logic [NCLI-1:0] clients;
        logic [AW-1:0]   addr;
        logic            wr;
        logic [SZW-1:0]  size;
        logic [CIDW-1:0] first;
    } aw_cap_t;

    typedef struct packed {
        logic            valid;
        logic [AW-1:0]   addr;
        logic [CIDW-1:0] client;
        logic            wr;
        logic [SZW-1:0]  size;
    } aw_snoop_t;

    function automatic logic [NCLI-1:0] client_bit(input logic [CIDW-1:0] cid);
        return NCLI'(1) << cid;
    endfunction

    function automatic logic op_allowed(input logic [1:0] opm, input logic wr);
        return wr ? opm[1] : opm[0];
    endfunction

    function automatic logic [DW-1:0] pack_info(input aw_cap_t c);
        logic [DW-1:0] w;
        w          = '0;
        w[DW-1]    = c.valid;
        w[8+:SZW]  = c.size;
        w[0]       = c.wr;
        return w;
    endfunction

endpackage

// File: rtl/aw_cmp.sv
module aw_cmp
    import aw_pkg::*;
(
    input  aw_cfg_t   cfg,
    input  aw_snoop_t snp,
    output logic      hit
);
    logic in_win;
    logic cli_ok;
    logic op_ok;

    always_comb begin
        in_win = (snp.addr >= cfg.lo) && (snp.addr <= cfg.hi);
        cli_ok = cfg.cmask[snp.client];
        op_ok  = op_allowed(cfg.opm, snp.wr);
        hit    = snp.valid && in_win && cli_ok && op_ok;
    end
endmodule

// File: rtl/aw_lowest.sv
module aw_lowest #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  grant
);
    always_comb begin
        any   = 1'b0;
        idx   = '0;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any   = 1'b1;
                idx   = IW'(i);
                grant = N'(1) << i;
            end
        end
    end

    // R12
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    // R12
    grant_is_req_chk: assert property (@(posedge clk) disable iff (rst)
        any |-> req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0));
endmodule

// File: rtl/aw_slot.sv
module aw_slot
    import aw_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          ack_cap,
    input  logic          ack_pend,
    input  aw_snoop_t     snp,
    output aw_cfg_t       cfg_q,
    output aw_cap_t       cap_q,
    output logic          pend_q
);
    logic    hit;
    aw_cap_t fresh;

    aw_cmp u_cmp (
        .cfg (cfg_q),
        .snp (snp),
        .hit (hit)
    );

    always_comb begin
        fresh         = '0;
        fresh.valid   = 1'b1;
        fresh.clients = client_bit(snp.client);
        fresh.addr    = snp.addr;
        fresh.wr      = snp.wr;
        fresh.size    = snp.size;
        fresh.first   = snp.client;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            cap_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0:    cfg_q.lo    <= cfg_wdata[AW-1:0];
                    2'd1:    cfg_q.hi    <= cfg_wdata[AW-1:0];
                    2'd2:    cfg_q.opm   <= cfg_wdata[1:0];
                    default: cfg_q.cmask <= cfg_wdata[NCLI-1:0];
                endcase
            end

            if (hit)
                pend_q <= 1'b1;
            else if (ack_pend)
                pend_q <= 1'b0;

            if (ack_cap || !cap_q.valid) begin
                cap_q <= hit ? fresh : '0;
            end else if (hit) begin
                cap_q.clients <= cap_q.clients | client_bit(snp.client);
            end
        end
    end

    // R6
    hit_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> pend_q);
    // R6
    pend_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(hit));
    // R10
    ack_clears_pend_chk: assert property (@(posedge clk) disable iff (rst)
        ack_pend && !hit |=> !pend_q);
    // R7
    cap_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        cap_q.valid && !ack_cap |=> $stable(cap_q.addr) && $stable(cap_q.first)
                                    && $stable(cap_q.size) && $stable(cap_q.wr));
    // R9
    ack_empties_cap_chk: assert property (@(posedge clk) disable iff (rst)
        ack_cap && !hit |=> !cap_q.valid && cap_q.clients == '0);
endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
    import aw_pkg::*;
#(
    parameter int NUM_WP = 4,
    localparam int REG_AW = $clog2(NUM_WP * SLOT_SPAN + SLOT_SPAN),
    localparam int SEL_W  = REG_AW - 3,
    localparam int IW     = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              snp_valid,
    input  logic [AW-1:0]     snp_addr,
    input  logic [CIDW-1:0]   snp_client,
    input  logic              snp_write,
    input  logic [SZW-1:0]    snp_size,
    output logic              irq
);
    aw_snoop_t   snp;
    logic [SEL_W-1:0] sel;
    logic [2:0]  off;
    logic        in_slots;
    logic        in_glob;

    aw_cfg_t     cfg_a [NUM_WP];
    aw_cap_t     cap_a [NUM_WP];
    logic [NUM_WP-1:0] pend_v;
    logic [NUM_WP-1:0] en_q;
    logic [NUM_WP-1:0] masked;
    logic [NUM_WP-1:0] grant;
    logic              any;
    logic [IW-1:0]     low_idx;
    logic [NUM_WP-1:0] gack;

    always_comb begin
        snp.valid  = snp_valid;
        snp.addr   = snp_addr;
        snp.client = snp_client;
        snp.wr     = snp_write;
        snp.size   = snp_size;
        sel        = reg_addr[REG_AW-1:3];
        off        = reg_addr[2:0];
        in_slots   = (int'(sel) < NUM_WP);
        in_glob    = (int'(sel) == NUM_WP);
        gack       = (reg_we && in_glob && off == GOFF_ACK) ? reg_wdata[NUM_WP-1:0] : '0;
    end

    for (genvar w = 0; w < NUM_WP; w++) begin : g_slot
        logic hit_me;
        assign hit_me = reg_we && in_slots && (int'(sel) == w);
        aw_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (hit_me && !off[2]),
            .cfg_sel   (off[1:0]),
            .cfg_wdata (reg_wdata),
            .ack_cap   (hit_me && off == OFF_CFRST),
            .ack_pend  (gack[w]),
            .snp       (snp),
            .cfg_q     (cfg_a[w]),
            .cap_q     (cap_a[w]),
            .pend_q    (pend_v[w])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (reg_we && in_glob && off == GOFF_EN)
            en_q <= reg_wdata[NUM_WP-1:0];
    end

    assign masked = pend_v & en_q;
    assign irq    = |masked;

    aw_lowest #(.N(NUM_WP)) u_low (
        .clk   (clk),
        .rst   (rst),
        .req   (masked),
        .any   (any),
        .idx   (low_idx),
        .grant (grant)
    );

    always_comb begin
        reg_rdata = '0;
        if (in_slots) begin
            case (off)
                OFF_LO:    reg_rdata = DW'(cfg_a[sel].lo);
                OFF_HI:    reg_rdata = DW'(cfg_a[sel].hi);
                OFF_OPM:   reg_rdata = DW'(cfg_a[sel].opm);
                OFF_CMASK: reg_rdata = DW'(cfg_a[sel].cmask);
                OFF_CCLI:  reg_rdata = DW'(cap_a[sel].clients);
                OFF_CADDR: reg_rdata = DW'(cap_a[sel].addr);
                OFF_CINFO: reg_rdata = pack_info(cap_a[sel]);
                default:   reg_rdata = DW'(cap_a[sel].first);
            endcase
        end else if (in_glob) begin
            case (off)
                GOFF_EN:  reg_rdata = DW'(en_q);
                GOFF_RAW: reg_rdata = DW'(pend_v);
                GOFF_MSK: begin
                    reg_rdata[NUM_WP-1:0] = masked;
                    reg_rdata[23:16]      = 8'(low_idx);
                    reg_rdata[DW-1]       = any;
                end
                default:  reg_rdata = '0;
            endcase
        end
    end

    // R11
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|en_q) && (|pend_v));
    // R12
    lowest_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) == irq);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !irq);
endmodule

// File: tb/addr_watch_unit_bench.sv
module addr_watch_unit_bench;
    localparam int G = 32;

    typedef struct packed {
        logic        v;
        logic [31:0] a;
        logic [3:0]  c;
        logic        w;
        logic        exp;
    } vec_t;

    // wp0 window 0x1000..0x1FFF, writes only, clients 2 and 5
    localparam vec_t VECS [8] = '{
        '{1'b1, 32'h0000_1000, 4'd2, 1'b1, 1'b1},  // R3 low bound
        '{1'b1, 32'h0000_1FFF, 4'd5, 1'b1, 1'b1},  // R3 high bound
        '{1'b1, 32'h0000_0FFF, 4'd2, 1'b1, 1'b0},  // R3 below
        '{1'b1, 32'h0000_2000, 4'd2, 1'b1, 1'b0},  // R3 above
        '{1'b1, 32'h0000_1800, 4'd3, 1'b1, 1'b0},  // R4 client off
        '{1'b1, 32'h0000_1800, 4'd2, 1'b0, 1'b0},  // R5 read off
        '{1'b0, 32'h0000_1800, 4'd5, 1'b1, 1'b0},  // R3 not valid
        '{1'b1, 32'h0000_1234, 4'd2, 1'b1, 1'b1}   // R6 mid window
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        snp_valid = 1'b0;
    logic [31:0] snp_addr = '0;
    logic [3:0]  snp_client = '0;
    logic        snp_write = 1'b0;
    logic [7:0]  snp_size = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    addr_watch_unit u_addr_watch_unit (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .snp_valid(snp_valid),
        .snp_addr(snp_addr), .snp_client(snp_client), .snp_write(snp_write),
        .snp_size(snp_size), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 6'(idx); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 6'(idx);
        #1 d = reg_rdata;
    endtask

    task automatic snoop(input logic v, input logic [31:0] a, input logic [3:0] c,
                         input logic w, input logic [7:0] s);
        @(negedge clk);
        snp_valid = v; snp_addr = a; snp_client = c; snp_write = w; snp_size = s;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(G + 1, rv);  check("R1 raw status", rv, 32'h0);
        rd(G + 0, rv);  check("R1 enable", rv, 32'h0);
        rd(1 * 8 + 6, rv); check("R1 capture info", rv, 32'h0);

        // R2 readback on wp2 (operation mask 0 keeps it inert)
        wr(2 * 8 + 0, 32'h0000_A000);
        wr(2 * 8 + 1, 32'h0000_B000);
        wr(2 * 8 + 3, 32'h0000_F00F);
        rd(2 * 8 + 0, rv); check("R2 low", rv, 32'h0000_A000);
        rd(2 * 8 + 1, rv); check("R2 high", rv, 32'h0000_B000);
        rd(2 * 8 + 3, rv); check("R2 cmask", rv, 32'h0000_F00F);
        wr(2 * 8 + 2, 32'h0000_0000);
        rd(2 * 8 + 2, rv); check("R2 opmask", rv, 32'h0);

        // vector table on wp0
        wr(0 * 8 + 0, 32'h0000_1000);
        wr(0 * 8 + 1, 32'h0000_1FFF);
        wr(0 * 8 + 2, 32'h0000_0002);
        wr(0 * 8 + 3, 32'h0000_0024);
        foreach (VECS[i]) begin
            wr(G + 3, 32'h1);
            wr(0 * 8 + 7, 32'h0);
            snoop(VECS[i].v, VECS[i].a, VECS[i].c, VECS[i].w, 8'h4);
            rd(G + 1, rv);
            check($sformatf("R3/R4/R5/R6 vector %0d", i), {31'b0, rv[0]}, {31'b0, VECS[i].exp});
        end
        rd(0 * 8 + 5, rv); check("R7 wp0 capture addr", rv, 32'h0000_1234);
        wr(G + 3, 32'h1);
        wr(0 * 8 + 7, 32'h0);

        // R7 / R8 on wp1: all clients, both operations
        wr(1 * 8 + 0, 32'h0000_0100);
        wr(1 * 8 + 1, 32'h0000_01FF);
        wr(1 * 8 + 2, 32'h0000_0003);
        wr(1 * 8 + 3, 32'h0000_FFFF);
        snoop(1'b1, 32'h0000_0150, 4'd7, 1'b1, 8'd4);
        snoop(1'b1, 32'h0000_0160, 4'd9, 1'b0, 8'd8);
        rd(1 * 8 + 5, rv); check("R7 capture addr", rv, 32'h0000_0150);
        rd(1 * 8 + 6, rv); check("R7 capture info", rv, 32'h8000_0401);
        rd(1 * 8 + 7, rv); check("R7 first client", rv, 32'd7);
        rd(1 * 8 + 4, rv); check("R8 client set", rv, 32'h0000_0280);

        // R11 enable gating
        rd(G + 1, rv); check("R6 raw pending wp1", rv, 32'h2);
        check("R11 irq masked off", {31'b0, irq}, 32'h0);
        rd(G + 2, rv); check("R11 masked status off", rv, 32'h0);
        wr(G + 0, 32'hA);
        check("R11 irq on", {31'b0, irq}, 32'h1);
        rd(G + 2, rv); check("R12 lowest is wp1", rv, 32'h8001_0002);

        // wp3: single address, reads, client 0
        wr(3 * 8 + 0, 32'h0000_5000);
        wr(3 * 8 + 1, 32'h0000_5000);
        wr(3 * 8 + 2, 32'h0000_0001);
        wr(3 * 8 + 3, 32'h0000_0001);
        snoop(1'b1, 32'h0000_5000, 4'd0, 1'b0, 8'd1);
        rd(G + 2, rv); check("R12 two pending", rv, 32'h8001_000A);
        wr(G + 3, 32'h2);
        rd(G + 2, rv); check("R12 lowest moves to wp3", rv, 32'h8003_0008);

        // R10 ack and hit in the same cycle
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 6'(G + 3); reg_wdata = 32'h8;
        snp_valid = 1'b1; snp_addr = 32'h0000_5000; snp_client = 4'd0;
        snp_write = 1'b0; snp_size = 8'd1;
        @(negedge clk);
        reg_we = 1'b0; snp_valid = 1'b0;
        rd(G + 1, rv); check("R10 hit beats ack", rv, 32'h8);
        wr(G + 3, 32'h8);
        rd(G + 1, rv); check("R10 ack clears", rv, 32'h0);
        check("R11 irq after ack", {31'b0, irq}, 32'h0);

        // R9 per-watchpoint capture release and recapture
        wr(1 * 8 + 7, 32'h0);
        rd(1 * 8 + 6, rv); check("R9 info emptied", rv, 32'h0);
        rd(1 * 8 + 4, rv); check("R9 clients emptied", rv, 32'h0);
        snoop(1'b1, 32'h0000_01A0, 4'd3, 1'b0, 8'd2);
        rd(1 * 8 + 5, rv); check("R9 recapture addr", rv, 32'h0000_01A0);
        rd(1 * 8 + 6, rv); check("R9 recapture info", rv, 32'h8000_0200);
        rd(1 * 8 + 7, rv); check("R9 recapture first", rv, 32'd3);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule